// File: doc/BRIEF.md
# Multi-lane serial ADC frame deserializer

This block sits behind the pins of a multi-channel sigma-delta converter that pushes its conversion results out over one, two, four or eight serial data lines. It runs on the converter's own interface clock. An active-low ready pulse from the converter opens each conversion frame. The block reassembles a 32-bit word for every channel. Each word holds an 8-bit header in the top byte and a 24-bit two's-complement sample below it. The header travels with the sample and is not removed.

The words leave by two routes. The first is a parallel bus with one 32-bit slot and one valid strobe per channel. The second is a valid/ready word stream that sends the enabled channels one after another and flags the first word of each frame. While the words are being gathered, the block also checks the header against a code computed over the sample. Any channel that fails raises a sticky error bit.

Stream rules: a word on `ser_data` counts as taken on a clock edge where both `ser_valid` and `ser_ready` are high. While `ser_ready` is low, the word and its flags are held unchanged. The stream keeps one frame of storage. A frame that completes while words of an earlier frame are still waiting is not put on the stream, although it still appears on the parallel bus. The parallel bus has no back-pressure.

Top module: `msadc_deser`

## Requirements
- R1: After reset, `par_valid`, `ser_valid`, `ser_sof` and `crc_err` are all zero, and `par_data` is zero.
- R2: `lane_mode` selects the active line count: 0 selects 1 line, 1 selects 2, 2 selects 4 and 3 selects 8. The value is latched on the edge that samples `rdy_n` low. With N lines, line k carries channels k, k+N, k+2N and so on, in that order. A frame lasts 32×NUM_CH/N bits per line. The first bit is sampled on the edge after the one that sees `rdy_n` low.
- R3: Every channel word is received MSB first. Bits 31:24 hold the header and bits 23:0 hold the sample. The whole 32-bit word is presented unchanged in `par_data[32c+31:32c]` for channel c.
- R4: `par_valid[c]` is high for exactly one cycle. That cycle follows the clock edge after the edge that samples a frame's last bit.
- R5: A channel whose `ch_en` bit is low at frame end gets no `par_valid` pulse. Its `par_data` slot keeps its previous value, it is left out of the stream, and it cannot set its `crc_err` bit.
- R6: The stream presents the enabled channels of a frame in ascending channel order. `ser_sof` is high with the first of them only.
- R7: While `ser_valid` is high and `ser_ready` is low, `ser_data`, `ser_sof` and `ser_valid` hold steady. A frame that completes while a word is still pending is not streamed.
- R8: The check code is CRC-8 with polynomial x^8+x^2+x+1 (0x07) and initial value 0. It is computed MSB first over the 24 sample bits and compared with the 8 header bits. A mismatch sets `crc_err[c]` in the same cycle as `par_valid`. The bit stays set through later frames that pass the check.
- R9: `crc_clr` high clears every `crc_err` bit on the next edge. If a mismatch arrives on that same edge, the clear wins.
- R10: A `rdy_n` pulse in the middle of a frame discards the partial frame and restarts the bit count. No `par_valid` pulse comes from the abandoned frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdy_n | input | 1 | Active-low frame start pulse |
| lanes | input | 8 | Serial data lines, line k on bit k |
| lane_mode | input | 2 | Active line count code (R2) |
| ch_en | input | NUM_CH | Per-channel output enable |
| crc_clr | input | 1 | Clears all check error bits |
| ser_ready | input | 1 | Stream consumer ready |
| par_data | output | 32×NUM_CH | Per-channel words, channel c at bits 32c+31:32c |
| par_valid | output | NUM_CH | Per-channel new-word strobes |
| ser_data | output | 32 | Stream word |
| ser_valid | output | 1 | Stream word valid |
| ser_sof | output | 1 | First word of a frame on the stream |
| crc_err | output | NUM_CH | Sticky per-channel check mismatch |

## Verification
A bit counter that is off by one shifts every channel word by one bit. It also moves the `par_valid` pulse by a cycle. Both show up on the first frame after the fault. A wrong line-to-channel mapping places correct words in the wrong `par_data` slots, and it does so only in the affected line mode, so each of the four modes is checked. Damage to the stream pending mask shows as a missing, repeated or out-of-order word, or as a misplaced `ser_sof` while the frame drains. A lost sticky bit appears at `crc_err` one frame later, when a clean frame follows a failing one.

// File: rtl/msadc_pkg.sv
package msadc_pkg;
  localparam int WORD_W = 32;
  localparam int HDR_W  = 8;
  localparam int SMP_W  = 24;
  localparam logic [7:0] CRC_POLY = 8'h07;

  // bit-wise loop unrolls into a single combinational parallel network
  function automatic logic [HDR_W-1:0] crc8_sample(input logic [SMP_W-1:0] s);
    logic [HDR_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = SMP_W - 1; i >= 0; i--) begin
      fb = c[HDR_W-1] ^ s[i];
      c  = {c[HDR_W-2:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/msadc_capture.sv
module msadc_capture #(
  parameter int NUM_CH    = 8,
  parameter int MAX_LANES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rdy_n,
  input  logic [MAX_LANES-1:0]          lanes,
  input  logic [1:0]                    lane_mode,
  output logic [NUM_CH-1:0][31:0]       words,
  output logic                          fin
);
  localparam int LOG_CH = $clog2(NUM_CH);
  localparam int LOG_LN = $clog2(MAX_LANES);
  localparam int LIM    = (LOG_CH < LOG_LN) ? LOG_CH : LOG_LN;
  localparam int CNT_W  = $clog2(32 * NUM_CH);
  localparam int LNW    = (LOG_LN > 0) ? LOG_LN : 1;

  logic [CNT_W-1:0] cnt;
  logic [1:0]       lsh_q, lsh_eff;
  logic             act;
  logic [CNT_W-1:0] last;

  assign lsh_eff = (int'(lane_mode) > LIM) ? 2'(LIM) : lane_mode;
  assign last    = CNT_W'(((32 * NUM_CH) >> lsh_q) - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      act   <= 1'b0;
      fin   <= 1'b0;
      lsh_q <= '0;
    end else if (!rdy_n) begin
      cnt   <= '0;
      act   <= 1'b1;
      fin   <= 1'b0;
      lsh_q <= lsh_eff;
    end else if (act) begin
      cnt <= cnt + 1'b1;
      fin <= (cnt == last);
      if (cnt == last) act <= 1'b0;
    end else begin
      fin <= 1'b0;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    int  li, sl;
    logic take;
    always_comb begin
      li   = c & ((1 << lsh_q) - 1);
      sl   = c >> lsh_q;
      take = act && rdy_n && (sl == int'(cnt >> 5));
    end
    always_ff @(posedge clk) begin
      if (!rst_n)    words[c] <= '0;
      else if (take) words[c] <= {words[c][30:0], lanes[li[LNW-1:0]]};
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (cnt <= last));
  // R4
  fin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin);
endmodule

// File: rtl/msadc_crc_check.sv
module msadc_crc_check
  import msadc_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fin,
  input  logic                    clr,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0][31:0] words,
  output logic [NUM_CH-1:0]       flags
);
  logic [NUM_CH-1:0] mis;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assign mis[c] = crc8_sample(words[c][SMP_W-1:0]) != words[c][WORD_W-1:SMP_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   flags <= '0;
    else if (clr) flags <= '0;
    else if (fin) flags <= flags | (mis & ch_en);
  end

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flags & $past(flags)) == $past(flags)));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (flags == '0));
endmodule

// File: rtl/msadc_stream.sv
module msadc_stream #(
  parameter int NUM_CH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0][31:0] words,
  input  logic                    ser_ready,
  output logic [31:0]             ser_data,
  output logic                    ser_valid,
  output logic                    ser_sof
);
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic [NUM_CH-1:0][31:0] hold;
  logic [NUM_CH-1:0]       pend;
  logic                    sof_q;
  logic [IW-1:0]           sel;

  always_comb begin
    sel = '0;
    for (int c = NUM_CH - 1; c >= 0; c--)
      if (pend[c]) sel = IW'(c);
  end

  assign ser_valid = |pend;
  assign ser_data  = hold[sel];
  assign ser_sof   = sof_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold  <= '0;
      pend  <= '0;
      sof_q <= 1'b0;
    end else if (load && !(|pend)) begin
      hold  <= words;
      pend  <= ch_en;
      sof_q <= |ch_en;
    end else if (ser_valid && ser_ready) begin
      pend[sel] <= 1'b0;
      sof_q     <= 1'b0;
    end
  end

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_data) && $stable(ser_sof)));
  // R6
  sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sof |-> ser_valid);
endmodule

// File: rtl/msadc_deser.sv
module msadc_deser #(
  parameter int NUM_CH    = 8,
  parameter int MAX_LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   rdy_n,
  input  logic [MAX_LANES-1:0]   lanes,
  input  logic [1:0]             lane_mode,
  input  logic [NUM_CH-1:0]      ch_en,
  input  logic                   crc_clr,
  input  logic                   ser_ready,
  output logic [NUM_CH*32-1:0]   par_data,
  output logic [NUM_CH-1:0]      par_valid,
  output logic [31:0]            ser_data,
  output logic                   ser_valid,
  output logic                   ser_sof,
  output logic [NUM_CH-1:0]      crc_err
);
  logic [NUM_CH-1:0][31:0] words;
  logic                    fin;

  msadc_capture #(.NUM_CH(NUM_CH), .MAX_LANES(MAX_LANES)) u_cap (
    .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .lanes(lanes),
    .lane_mode(lane_mode), .words(words), .fin(fin));

  msadc_crc_check #(.NUM_CH(NUM_CH)) u_crc (
    .clk(clk), .rst_n(rst_n), .fin(fin), .clr(crc_clr), .ch_en(ch_en),
    .words(words), .flags(crc_err));

  msadc_stream #(.NUM_CH(NUM_CH)) u_str (
    .clk(clk), .rst_n(rst_n), .load(fin), .ch_en(ch_en), .words(words),
    .ser_ready(ser_ready), .ser_data(ser_data), .ser_valid(ser_valid),
    .ser_sof(ser_sof));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_par
    always_ff @(posedge clk) begin
      if (!rst_n)                 par_data[c*32 +: 32] <= '0;
      else if (fin && ch_en[c])   par_data[c*32 +: 32] <= words[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) par_valid <= '0;
    else        par_valid <= fin ? ch_en : '0;
  end

  // R4
  par_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|par_valid) |=> !(|par_valid));
endmodule

// File: tb/msadc_deser_bench.sv
module msadc_deser_bench;
  localparam int NCH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdy_n = 1'b1;
  logic [7:0] lanes = '0;
  logic [1:0] lane_mode = 2'd3;
  logic [NCH-1:0] ch_en = '1;
  logic crc_clr = 1'b0;
  logic ser_ready = 1'b0;
  logic [NCH*32-1:0] par_data;
  logic [NCH-1:0] par_valid, crc_err;
  logic [31:0] ser_data;
  logic ser_valid, ser_sof;

  int checks = 0;
  int errors = 0;
  logic [31:0] fw [NCH];
  logic [31:0] keep [NCH];

  always #2.5 clk = ~clk;

  msadc_deser u_msadc_deser (
    .clk(clk), .rst_n(rst_n), .rdy_n(rdy_n), .lanes(lanes),
    .lane_mode(lane_mode), .ch_en(ch_en), .crc_clr(crc_clr),
    .ser_ready(ser_ready), .par_data(par_data), .par_valid(par_valid),
    .ser_data(ser_data), .ser_valid(ser_valid), .ser_sof(ser_sof),
    .crc_err(crc_err));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // polynomial long division of sample*x^8 by 0x107
  function automatic logic [7:0] ref_crc(input logic [23:0] s);
    logic [31:0] r;
    r = {s, 8'h00};
    for (int i = 31; i >= 8; i--)
      if (r[i]) r = r ^ (32'h107 << (i - 8));
    return r[7:0];
  endfunction

  function automatic logic [31:0] mk(input logic [23:0] s, input bit bad);
    logic [7:0] h;
    h = ref_crc(s) ^ (bad ? 8'h5A : 8'h00);
    return {h, s};
  endfunction

  task automatic fill(input int seed, input logic [NCH-1:0] badm);
    for (int c = 0; c < NCH; c++)
      fw[c] = mk(24'(seed * 24'h01_3579 + c * 24'h11_0F0D + 24'h8), badm[c]);
  endtask

  // drives a frame; nbits < full length leaves it abandoned
  task automatic send(input int mode, input int nbits);
    int n, per;
    n = 1 << mode;
    per = 32 * NCH / n;
    lane_mode = 2'(mode);
    rdy_n = 1'b0;
    @(negedge clk);
    rdy_n = 1'b1;
    for (int b = 0; b < per && b < nbits; b++) begin
      for (int k = 0; k < 8; k++) begin
        if (k < n) lanes[k] = fw[k + (b / 32) * n][31 - (b % 32)];
        else       lanes[k] = 1'b0;
      end
      @(negedge clk);
    end
    lanes = '0;
  endtask

  task automatic full_frame(input int mode);
    send(mode, 1 << 30);
    @(negedge clk);
  endtask

  task automatic drain(input string req, input logic [NCH-1:0] m);
    bit first;
    first = 1'b1;
    for (int c = 0; c < NCH; c++) begin
      if (m[c]) begin
        chk(req, {63'd0, ser_valid}, 64'd1);
        chk(req, {32'd0, ser_data}, {32'd0, keep[c]});
        chk("R6", {63'd0, ser_sof}, {63'd0, first});
        first = 1'b0;
        ser_ready = 1'b1;
        @(negedge clk);
        ser_ready = 1'b0;
      end
    end
    chk(req, {63'd0, ser_valid}, 64'd0);
  endtask

  task automatic check_par(input string req, input logic [NCH-1:0] m);
    for (int c = 0; c < NCH; c++)
      if (m[c]) chk(req, {32'd0, par_data[c*32 +: 32]}, {32'd0, fw[c]});
  endtask

  task automatic t_reset;
    chk("R1", {56'd0, par_valid}, 64'd0);
    chk("R1", {62'd0, ser_valid, ser_sof}, 64'd0);
    chk("R1", {56'd0, crc_err}, 64'd0);
    chk("R1", {63'd0, |par_data}, 64'd0);
  endtask

  task automatic t_modes;
    for (int m = 3; m >= 0; m--) begin
      fill(m + 1, '0);
      full_frame(m);
      check_par("R2", '1);
      chk("R4", {56'd0, par_valid}, 64'hFF);
      chk("R8", {56'd0, crc_err}, 64'd0);
      for (int c = 0; c < NCH; c++) keep[c] = fw[c];
      @(negedge clk);
      chk("R4", {56'd0, par_valid}, 64'd0);
      drain("R6", '1);
    end
    chk("R3", {32'd0, par_data[31:0]}, {32'd0, fw[0]});
  endtask

  task automatic t_crc;
    fill(9, 8'h28);
    full_frame(3);
    chk("R8", {56'd0, crc_err}, 64'h28);
    for (int c = 0; c < NCH; c++) keep[c] = fw[c];
    drain("R6", '1);
    fill(10, '0);
    full_frame(3);
    chk("R8", {56'd0, crc_err}, 64'h28);
    for (int c = 0; c < NCH; c++) keep[c] = fw[c];
    drain("R6", '1);
    crc_clr = 1'b1;
    @(negedge clk);
    crc_clr = 1'b0;
    chk("R9", {56'd0, crc_err}, 64'd0);
  endtask

  task automatic t_clear_wins;
    fill(11, 8'h01);
    send(3, 1 << 30);
    crc_clr = 1'b1;
    @(negedge clk);
    crc_clr = 1'b0;
    chk("R9", {56'd0, crc_err}, 64'd0);
    for (int c = 0; c < NCH; c++) keep[c] = fw[c];
    drain("R6", '1);
  endtask

  task automatic t_enable;
    logic [31:0] prev [NCH];
    for (int c = 0; c < NCH; c++) prev[c] = par_data[c*32 +: 32];
    ch_en = 8'h55;
    fill(12, 8'h02);
    full_frame(2);
    chk("R5", {56'd0, par_valid}, 64'h55);
    chk("R5", {56'd0, crc_err}, 64'd0);
    check_par("R5", 8'h55);
    for (int c = 0; c < NCH; c++)
      if (!ch_en[c]) chk("R5", {32'd0, par_data[c*32 +: 32]}, {32'd0, prev[c]});
    for (int c = 0; c < NCH; c++) keep[c] = fw[c];
    drain("R5", 8'h55);
    ch_en = '1;
  endtask

  task automatic t_backpressure;
    logic [31:0] d0;
    fill(13, '0);
    full_frame(3);
    for (int c = 0; c < NCH; c++) keep[c] = fw[c];
    d0 = ser_data;
    repeat (3) @(negedge clk);
    chk("R7", {63'd0, ser_valid}, 64'd1);
    chk("R7", {32'd0, ser_data}, {32'd0, d0});
    chk("R7", {63'd0, ser_sof}, 64'd1);
    fill(14, '0);
    full_frame(3);
    check_par("R7", '1);
    drain("R7", '1);
  endtask

  task automatic t_restart;
    bit seen;
    fill(15, '0);
    seen = 1'b0;
    send(3, 20);
    fill(16, '0);
    fork
      send(3, 1 << 30);
      begin
        for (int i = 0; i < 33; i++) begin
          @(negedge clk);
          if (|par_valid) seen = 1'b1;
        end
      end
    join
    chk("R10", {63'd0, seen}, 64'd0);
    @(negedge clk);
    chk("R10", {56'd0, par_valid}, 64'hFF);
    check_par("R10", '1);
    for (int c = 0; c < NCH; c++) keep[c] = fw[c];
    drain("R10", '1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_crc();
        t_clear_wins();
        t_enable();
        t_backpressure();
        t_restart();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule